// File: doc/BRIEF.md
# Programmable Multi-Line Edge Detector

This block watches a wide bus of single-bit trace lines, up to 256 of them, and flags the transitions that software asks it to look for. Each line has its own 2-bit selector that chooses rising edges, falling edges, or both. A separate one-bit gate per line lets software silence chosen lines without reprogramming their selectors. The block produces a per-line event vector and a single combined event flag that a trigger or capture stage further down the chip can consume.

Configuration goes through a plain 32-bit register port with word-aligned byte addresses. One run of words holds the packed selectors at sixteen lines per word. A second run holds the gate bits at thirty-two lines per word. A control word carries the enable. Addresses that fall outside the implemented words are harmless: they read as zero, and writes to them are dropped.

Top module: `edge_watch`

## Requirements
- R1: Line i takes its 2-bit selector from selector word i/16, bits [(i mod 16)*2+1 : (i mod 16)*2]. Code 00 reports a 0-to-1 transition of that line.
- R2: Selector code 01 reports a 1-to-0 transition of the line.
- R3: Selector code 10 reports a transition in either direction.
- R4: Selector code 11 is reserved and behaves exactly like code 00.
- R5: Line i is gated by bit (i mod 32) of gate word i/32. A gate bit of 1 passes the line's events and a gate bit of 0 suppresses them.
- R6: A qualifying transition, sampled at one clock edge against the value sampled at the edge before, raises the line's bit in `line_evt` right after that edge, for exactly one cycle. A line that holds steady raises nothing.
- R7: Bit 0 of the control word at byte address 0x780 enables detection. While it is 0, `line_evt` stays zero. Lines that change while detection is disabled produce no event when it is enabled again.
- R8: `any_evt` equals the OR of `line_evt` from the previous cycle.
- R9: Selector word n (0..15) sits at byte address 0x808+4n and gate word n (0..7) at 0x848+4n. A read strobe returns the addressed word on `cfg_rdata` after the next clock edge, and `cfg_rdata` holds its value when no read is made.
- R10: Reads of unaligned or unimplemented addresses return zero, and writes to them change no register. Bits 31:1 of the control word read as zero.
- R11: After reset, every register, `line_evt`, `any_evt` and `cfg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trace_in | input | N_LINES | Monitored trace lines |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Byte address of the register access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after the read strobe |
| line_evt | output | N_LINES | Per-line event pulses |
| any_evt | output | 1 | Combined event flag |

## Verification
The checker module tests several rules on every cycle. It checks that the event vector is empty while detection is disabled, that no event appears on a line whose gate bit was clear, and that a bus held steady produces no events. It also checks that the combined flag trails the OR of the vector by one cycle, that read data holds between reads, and that unimplemented addresses read zero. Only the bench scenarios can show that each selector code picks the correct transition direction on the correct line, and that selector and gate fields land at the bit positions given. The same applies to the rule that re-enabling produces no false edges and to register read-back after writes.

// File: rtl/edge_watch_pkg.sv
package edge_watch_pkg;

    localparam int unsigned WORD_W         = 32;
    localparam int unsigned SEL_PER_WORD   = 16;
    localparam int unsigned GATE_PER_WORD  = 32;
    localparam int unsigned SEL_SLOTS      = 16;
    localparam int unsigned GATE_SLOTS     = 8;

    localparam logic [11:0] CTRL_ADDR      = 12'h780;
    localparam logic [11:0] SEL_ADDR0      = 12'h808;
    localparam logic [11:0] GATE_ADDR0     = 12'h848;

    typedef enum logic [1:0] {
        SEL_RISE = 2'b00,
        SEL_FALL = 2'b01,
        SEL_BOTH = 2'b10,
        SEL_RSVD = 2'b11
    } edge_sel_e;

    // Reserved code falls back to rising-edge detection.
    function automatic logic edge_hit(input edge_sel_e sel, input logic prev, input logic cur);
        logic hit;
        case (sel)
            SEL_FALL: hit = prev & ~cur;
            SEL_BOTH: hit = prev ^ cur;
            default:  hit = ~prev & cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/edge_watch_regs.sv
module edge_watch_regs
    import edge_watch_pkg::*;
#(
    parameter int unsigned N_LINES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [11:0]          cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    output logic                 det_en,
    output logic [2*N_LINES-1:0] sel_flat,
    output logic [N_LINES-1:0]   gate_flat
);
    localparam int unsigned SEL_WORDS  = N_LINES / SEL_PER_WORD;
    localparam int unsigned GATE_WORDS = N_LINES / GATE_PER_WORD;

    typedef struct packed {
        logic                                en;
        logic [SEL_WORDS-1:0][WORD_W-1:0]    sel;
        logic [GATE_WORDS-1:0][WORD_W-1:0]   gate;
        logic [WORD_W-1:0]                   rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic                  aligned;
    logic                  ctrl_hit;
    logic [SEL_WORDS-1:0]  sel_hit;
    logic [GATE_WORDS-1:0] gate_hit;

    always_comb begin
        aligned  = (cfg_addr[1:0] == 2'b00);
        ctrl_hit = aligned && (cfg_addr == CTRL_ADDR);
        for (int n = 0; n < SEL_WORDS; n++) begin
            sel_hit[n] = aligned && (cfg_addr == SEL_ADDR0 + 12'(4 * n));
        end
        for (int n = 0; n < GATE_WORDS; n++) begin
            gate_hit[n] = aligned && (cfg_addr == GATE_ADDR0 + 12'(4 * n));
        end
    end

    always_comb begin
        r_d = r_q;
        if (cfg_wr) begin
            if (ctrl_hit) begin
                r_d.en = cfg_wdata[0];
            end
            for (int n = 0; n < SEL_WORDS; n++) begin
                if (sel_hit[n]) begin
                    r_d.sel[n] = cfg_wdata;
                end
            end
            for (int n = 0; n < GATE_WORDS; n++) begin
                if (gate_hit[n]) begin
                    r_d.gate[n] = cfg_wdata;
                end
            end
        end
        if (cfg_rd) begin
            r_d.rdata = '0;
            if (ctrl_hit) begin
                r_d.rdata[0] = r_q.en;
            end
            for (int n = 0; n < SEL_WORDS; n++) begin
                if (sel_hit[n]) begin
                    r_d.rdata = r_q.sel[n];
                end
            end
            for (int n = 0; n < GATE_WORDS; n++) begin
                if (gate_hit[n]) begin
                    r_d.rdata = r_q.gate[n];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_rdata = r_q.rdata;
    assign det_en    = r_q.en;
    assign sel_flat  = r_q.sel;
    assign gate_flat = r_q.gate;

endmodule

// File: rtl/edge_watch_detect.sv
module edge_watch_detect
    import edge_watch_pkg::*;
#(
    parameter int unsigned N_LINES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 det_en,
    input  logic [N_LINES-1:0]   trace_in,
    input  logic [2*N_LINES-1:0] sel_flat,
    input  logic [N_LINES-1:0]   gate_flat,
    output logic [N_LINES-1:0]   line_evt
);
    typedef struct packed {
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] evt;
    } det_t;

    det_t s_d, s_q;
    logic [N_LINES-1:0] hit;

    // One comparator per line, each reading its own selector field.
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign hit[i] = edge_hit(edge_sel_e'(sel_flat[2*i +: 2]), s_q.prev[i], trace_in[i]);
    end

    always_comb begin
        s_d      = s_q;
        // The previous-value copy follows the bus even while disabled,
        // so enabling never compares against a stale sample.
        s_d.prev = trace_in;
        s_d.evt  = hit & gate_flat & {N_LINES{det_en}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_evt = s_q.evt;

endmodule

// File: rtl/edge_watch_merge.sv
module edge_watch_merge #(
    parameter int unsigned N_LINES = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_evt,
    output logic               any_evt
);
    logic any_d, any_q;

    always_comb begin
        any_d = |line_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            any_q <= 1'b0;
        end else begin
            any_q <= any_d;
        end
    end

    assign any_evt = any_q;

endmodule

// File: rtl/edge_watch.sv
module edge_watch
    import edge_watch_pkg::*;
#(
    parameter int unsigned N_LINES = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] trace_in,
    input  logic               cfg_wr,
    input  logic               cfg_rd,
    input  logic [11:0]        cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    output logic [N_LINES-1:0] line_evt,
    output logic               any_evt
);
    logic                 det_en;
    logic [2*N_LINES-1:0] sel_flat;
    logic [N_LINES-1:0]   gate_flat;

    edge_watch_regs #(.N_LINES(N_LINES)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .det_en    (det_en),
        .sel_flat  (sel_flat),
        .gate_flat (gate_flat)
    );

    edge_watch_detect #(.N_LINES(N_LINES)) i_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_en    (det_en),
        .trace_in  (trace_in),
        .sel_flat  (sel_flat),
        .gate_flat (gate_flat),
        .line_evt  (line_evt)
    );

    edge_watch_merge #(.N_LINES(N_LINES)) i_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_evt (line_evt),
        .any_evt  (any_evt)
    );

endmodule

// File: rtl/edge_watch_chk.sv
module edge_watch_chk
    import edge_watch_pkg::*;
#(
    parameter int unsigned N_LINES = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] trace_in,
    input logic               cfg_rd,
    input logic [11:0]        cfg_addr,
    input logic [31:0]        cfg_rdata,
    input logic [N_LINES-1:0] line_evt,
    input logic               any_evt,
    input logic               det_en,
    input logic [N_LINES-1:0] gate_flat
);
    localparam int unsigned SEL_WORDS  = N_LINES / SEL_PER_WORD;
    localparam int unsigned GATE_WORDS = N_LINES / GATE_PER_WORD;

    logic armed_q;
    logic mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        mapped = (cfg_addr[1:0] == 2'b00) &&
                 ((cfg_addr == CTRL_ADDR) ||
                  (cfg_addr >= SEL_ADDR0  && cfg_addr < SEL_ADDR0  + 12'(4 * SEL_WORDS)) ||
                  (cfg_addr >= GATE_ADDR0 && cfg_addr < GATE_ADDR0 + 12'(4 * GATE_WORDS)));
    end

    p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> line_evt == '0);

    p_gate_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (line_evt & ~$past(gate_flat)) == '0);

    p_steady_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && trace_in == $past(trace_in)) |=> line_evt == '0);

    p_any_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> any_evt == $past(|line_evt));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> $stable(cfg_rdata));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && !mapped) |=> cfg_rdata == '0);

endmodule

bind edge_watch edge_watch_chk #(.N_LINES(N_LINES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trace_in  (trace_in),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .line_evt  (line_evt),
    .any_evt   (any_evt),
    .det_en    (det_en),
    .gate_flat (gate_flat)
);

// File: tb/test_edge_watch.sv
module test_edge_watch;
    localparam int N = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  trace_in;
    logic          cfg_wr, cfg_rd;
    logic [11:0]   cfg_addr;
    logic [31:0]   cfg_wdata;
    logic [31:0]   cfg_rdata;
    logic [N-1:0]  line_evt;
    logic          any_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0]  sel_m [16];
    logic [31:0]  gate_m [8];
    logic         en_m;
    logic [N-1:0] cur_tr;
    logic [N-1:0] last_exp;

    always #10 clk = ~clk;

    edge_watch #(.N_LINES(N)) i_edge_watch (
        .clk(clk), .rst_n(rst_n), .trace_in(trace_in),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .line_evt(line_evt), .any_evt(any_evt)
    );

    function automatic logic [N-1:0] model(input logic [N-1:0] p, input logic [N-1:0] c);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            logic [1:0] code;
            logic h;
            code = sel_m[i/16][(i%16)*2 +: 2];
            if (code == 2'b01)      h = p[i] & ~c[i];
            else if (code == 2'b10) h = p[i] ^ c[i];
            else                    h = ~p[i] & c[i];
            r[i] = h & gate_m[i/32][i%32] & en_m;
        end
        return r;
    endfunction

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a == 12'h780) return {31'h0, en_m};
        if (a >= 12'h808 && a <= 12'h844) return sel_m[(a - 12'h808) >> 2];
        if (a >= 12'h848 && a <= 12'h864) return gate_m[(a - 12'h848) >> 2];
        return 32'h0;
    endfunction

    function automatic logic [N-1:0] rand_vec();
        logic [N-1:0] v;
        for (int k = 0; k < N/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] nt, input string tag);
        logic [N-1:0] exp;
        @(negedge clk);
        trace_in = nt;
        @(posedge clk);
        #1;
        exp = model(cur_tr, nt);
        check(line_evt, exp, tag);
        check({{(N-1){1'b0}}, any_evt}, {{(N-1){1'b0}}, |last_exp}, "R8 combined flag lag");
        last_exp = exp;
        cur_tr   = nt;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1;
        if (a[1:0] == 2'b00) begin
            if (a == 12'h780) en_m = d[0];
            else if (a >= 12'h808 && a <= 12'h844) sel_m[(a - 12'h808) >> 2] = d;
            else if (a >= 12'h848 && a <= 12'h864) gate_m[(a - 12'h848) >> 2] = d;
        end
        @(negedge clk);
        cfg_wr = 1'b0;
        last_exp = '0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        @(posedge clk);
        #1;
        check({{(N-32){1'b0}}, cfg_rdata}, {{(N-32){1'b0}}, model_rd(a)}, tag);
        @(negedge clk);
        cfg_rd = 1'b0;
        last_exp = '0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog expired: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; trace_in = '0; cfg_wr = 0; cfg_rd = 0; cfg_addr = '0; cfg_wdata = '0;
        for (int k = 0; k < 16; k++) sel_m[k] = '0;
        for (int k = 0; k < 8; k++)  gate_m[k] = '0;
        en_m = 0; cur_tr = '0; last_exp = '0;
        repeat (3) @(posedge clk);
        #1;
        check(line_evt, '0, "R11 reset events");
        check({{(N-1){1'b0}}, any_evt}, '0, "R11 reset flag");
        check({{(N-32){1'b0}}, cfg_rdata}, '0, "R11 reset rdata");
        @(negedge clk);
        rst_n = 1'b1;
        rd(12'h780, "R11 control after reset");
        rd(12'h808, "R11 selector after reset");
        rd(12'h864, "R11 gate after reset");

        // Lines 0..3 use codes 00,01,10,11.
        wr(12'h808, 32'h0000_00E4);
        wr(12'h848, 32'h0000_000F);
        step(256'hF, "R7 disabled no events");
        wr(12'h780, 32'h1);
        step(256'hF, "R7 no false edge after enable");
        step(256'h0, "R2 R3 falling edges");
        step(256'hF, "R1 R3 R4 rising edges");
        step(256'hF, "R6 single pulse");
        wr(12'h848, 32'h0000_000B);
        step(256'h0, "R5 gate clear on line 2");
        step(256'hF, "R5 gate clear rising");

        // Top line: selector word 15 bits 31:30, gate word 7 bit 31.
        wr(12'h844, 32'h4000_0000);
        wr(12'h864, 32'h8000_0000);
        step({1'b1, 255'hF}, "R1 top line no rise event for fall code");
        step({1'b0, 255'hF}, "R2 top line falling edge");

        rd(12'h808, "R9 selector word 0 readback");
        rd(12'h844, "R9 selector word 15 readback");
        rd(12'h848, "R9 gate word 0 readback");
        rd(12'h864, "R9 gate word 7 readback");
        wr(12'h780, 32'hFFFF_FFFF);
        rd(12'h780, "R10 control upper bits zero");
        wr(12'h804, 32'hDEAD_BEEF);
        rd(12'h804, "R10 unmapped below selectors");
        wr(12'h868, 32'hDEAD_BEEF);
        rd(12'h868, "R10 unmapped above gates");
        wr(12'h80A, 32'hFFFF_FFFF);
        rd(12'h80A, "R10 unaligned read");
        rd(12'h808, "R10 unaligned write ignored");
        wr(12'h000, 32'h1234_5678);
        rd(12'h000, "R10 address zero");
        for (int k = 0; k < 8; k++) rd(12'h848 + 12'(4*k), "R10 gates untouched");

        wr(12'h780, 32'h0);
        step(~cur_tr, "R7 disabled toggle");
        wr(12'h780, 32'h1);

        for (int round = 0; round < 20; round++) begin
            for (int k = 0; k < 16; k++) wr(12'h808 + 12'(4*k), $urandom);
            for (int k = 0; k < 8; k++)  wr(12'h848 + 12'(4*k), $urandom);
            wr(12'h780, {31'h0, ($urandom % 5) != 0});
            for (int s = 0; s < 30; s++) begin
                step(cur_tr ^ (rand_vec() & rand_vec() & rand_vec()), "R1 R2 R3 R4 R5 R6 random");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule